// File: doc/BRIEF.md
# Masked Data Address Watchpoint Unit

This block holds a small bank of data watchpoints and compares every memory access of a load/store pipeline against all of them in the same cycle. Each watchpoint has a 32-bit address register and a 32-bit control register. The control register carries a load-trigger enable, a store-trigger enable and a 6-bit mask field. Together, the address and the mask describe an aligned region of 1 to 64 bytes. When an access of an enabled kind falls inside a watched region, the block raises `hit` combinationally and names the lowest-numbered matching watchpoint on `hit_idx`. The pipeline can then stop the access before it takes effect.

Software writes the watchpoint registers through a simple write port. Each write selects a watchpoint, chooses the address or the control register, and supplies the data. The mask field must hold ones from its top bit downward and zeros below them. When a written mask does not follow that form, the block keeps only its leading run of ones and clears every bit below the first zero. It stores the corrected mask, so the compare path never sees a malformed mask.

The block has no sequencing of its own. It is a register bank with a single-cycle compare and priority path, so no state machine appears in it.

Top module: `wp_unit`

## Requirements
- R1: After reset, every address register is 0 and every control register is 0. While reset is held, and before any write, `hit` and `hit_idx` are 0.
- R2: A write happens when `cfg_we`=1 at a rising clock edge. It goes to the watchpoint `cfg_idx`. With `cfg_sel`=0 it loads the address register, and with `cfg_sel`=1 it loads the control register. A written value is used for accesses from the next cycle onward. An access in the same cycle as the write is compared against the old contents.
- R3: Control bit 31 enables triggering on loads (`acc_is_store`=0). A load never hits a watchpoint whose bit 31 is clear.
- R4: Control bit 30 enables triggering on stores (`acc_is_store`=1). A store never hits a watchpoint whose bit 30 is clear.
- R5: A watchpoint whose control bits 31 and 30 are both clear never hits, whatever its address and mask hold.
- R6: The mask field is control bits [5:0]. The effective mask is that field with ones in bits 31..6. An access hits when (access address AND mask) equals (watch address AND mask). The region therefore starts at the watch address AND the mask and spans (NOT mask)+1 bytes. For example, field 0x00 gives 64 bytes, 0x3C gives 4 bytes and 0x3F gives 1 byte.
- R7: A mask field that is not a run of ones from bit 5 downward is reduced to its leading ones. For example, 0x35 acts as 0x30 and 0x1F acts as 0x00.
- R8: When several watchpoints hit, `hit_idx` gives the lowest-numbered one. When there is no hit, `hit_idx` is 0.
- R9: `hit` is a combinational result of the current cycle's access and is 0 whenever `acc_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the address register, 1 selects the control register |
| cfg_idx | input | IDX_W (2) | Watchpoint being written |
| cfg_wdata | input | ADDR_W (32) | Write data |
| acc_valid | input | 1 | A memory access is presented this cycle |
| acc_addr | input | ADDR_W (32) | Byte address of the access |
| acc_is_store | input | 1 | 1 for a store, 0 for a load |
| hit | output | 1 | The access matches an enabled watchpoint |
| hit_idx | output | IDX_W (2) | Lowest-numbered matching watchpoint, 0 when there is no hit |

## Verification
The two functions that can fall in the same cycle are a register write and an access compare that involves the same watchpoint. The bench provokes this directly, by turning on a load enable while presenting a load into the region. It also provokes it at random, mixing writes and accesses to a small address window in every cycle. Each result is judged against a bench model that is updated only after the clock edge. A correct design therefore shows the old configuration in the write cycle and the new one from the next cycle on.

// File: rtl/wp_pkg.sv
package wp_pkg;
    // Selects the register targeted by a configuration write.
    typedef enum logic {
        SEL_ADDR = 1'b0,
        SEL_CTRL = 1'b1
    } wp_reg_e;
endpackage

// File: rtl/wp_mask_norm.sv
// Reduces a mask field to its leading run of ones (from the top bit down).
module wp_mask_norm #(
    parameter int MASK_W = 6
) (
    input  logic [MASK_W-1:0] raw,
    output logic [MASK_W-1:0] norm
);
    for (genvar j = 0; j < MASK_W; j++) begin : g_bit
        // Bit j survives only if every bit above it is also set.
        assign norm[j] = &raw[MASK_W-1:j];
    end
endmodule

// File: rtl/wp_slot.sv
// One watchpoint: register storage plus its masked compare.
module wp_slot #(
    parameter int ADDR_W = 32,
    parameter int MASK_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr,
    input  logic              wr_ctrl,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_is_store,
    output logic              match
);
    localparam int LD_BIT = ADDR_W - 1;
    localparam int ST_BIT = ADDR_W - 2;
    localparam int HI_W   = ADDR_W - MASK_W;

    logic [ADDR_W-1:0] addr_q;
    logic [MASK_W-1:0] mask_q;
    logic              ld_en_q;
    logic              st_en_q;
    logic [MASK_W-1:0] mask_fixed;
    logic [ADDR_W-1:0] eff_mask;
    logic              kind_ok;
    logic              in_region;

    wp_mask_norm #(.MASK_W(MASK_W)) u_norm (
        .raw  (wdata[MASK_W-1:0]),
        .norm (mask_fixed)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            mask_q  <= '0;
            ld_en_q <= 1'b0;
            st_en_q <= 1'b0;
        end else begin
            if (wr_addr) begin
                addr_q <= wdata;
            end
            if (wr_ctrl) begin
                mask_q  <= mask_fixed;
                ld_en_q <= wdata[LD_BIT];
                st_en_q <= wdata[ST_BIT];
            end
        end
    end

    always_comb begin
        eff_mask  = {{HI_W{1'b1}}, mask_q};
        kind_ok   = acc_is_store ? st_en_q : ld_en_q;
        in_region = ((acc_addr ^ addr_q) & eff_mask) == '0;
        match     = acc_valid && kind_ok && in_region;
    end

    logic [MASK_W-1:0] mask_inv;
    assign mask_inv = ~mask_q;

    // R7
    mask_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask_inv + MASK_W'(1)) & mask_inv) == '0);

    // R5
    idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en_q && !st_en_q) |-> !match);

    // R2
    disable_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wdata[LD_BIT] && !wdata[ST_BIT]) |=> !match);

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_addr |=> $stable(addr_q));
endmodule

// File: rtl/wp_prio.sv
// Picks the lowest-numbered active request.
module wp_prio #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    // R8
    lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0)));

    // R8
    idle_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any |-> (idx == '0));
endmodule

// File: rtl/wp_unit.sv
// Bank of masked data watchpoints with a single-cycle priority compare.
module wp_unit #(
    parameter int NUM_BP = 4,
    parameter int ADDR_W = 32,
    parameter int MASK_W = 6,
    localparam int IDX_W = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_is_store,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx
);
    import wp_pkg::*;

    logic [NUM_BP-1:0] slot_match;

    for (genvar g = 0; g < NUM_BP; g++) begin : g_slot
        logic sel_me;
        assign sel_me = cfg_we && (cfg_idx == IDX_W'(g));

        wp_slot #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_addr      (sel_me && (cfg_sel == SEL_ADDR)),
            .wr_ctrl      (sel_me && (cfg_sel == SEL_CTRL)),
            .wdata        (cfg_wdata),
            .acc_valid    (acc_valid),
            .acc_addr     (acc_addr),
            .acc_is_store (acc_is_store),
            .match        (slot_match[g])
        );
    end

    wp_prio #(.N(NUM_BP), .IDX_W(IDX_W)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (slot_match),
        .any   (hit),
        .idx   (hit_idx)
    );

    // R9
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> acc_valid);
endmodule

// File: tb/wp_unit_test.sv
module wp_unit_test;
    localparam int NB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_is_store = 1'b0;
    logic        hit;
    logic [1:0]  hit_idx;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] m_addr [NB];
    logic [31:0] m_ctrl [NB];

    always #4 clk = ~clk;

    wp_unit uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_is_store(acc_is_store),
        .hit(hit), .hit_idx(hit_idx)
    );

    // Count leading ones of the field from bit 5 down, keep only those.
    function automatic logic [31:0] full_mask(input logic [5:0] f);
        int k = 0;
        bit run = 1'b1;
        logic [5:0] low;
        for (int j = 5; j >= 0; j--) begin
            if (run && f[j]) k++;
            else run = 1'b0;
        end
        low = 6'(6'h3f << (6 - k));
        return {26'h3ff_ffff, low};
    endfunction

    function automatic logic [2:0] model_hit(input logic v, input logic [31:0] a,
                                             input logic st);
        for (int i = 0; i < NB; i++) begin
            logic en;
            logic [31:0] m;
            en = st ? m_ctrl[i][30] : m_ctrl[i][31];
            m = full_mask(m_ctrl[i][5:0]);
            if (v && en && ((a & m) == (m_addr[i] & m))) return {1'b1, 2'(i)};
        end
        return 3'b000;
    endfunction

    task automatic compare(input string tag, input logic [2:0] exp);
        n_cmp++;
        if ({hit, hit_idx} !== exp) begin
            n_bad++;
            $display("FAIL %s: hit/idx actual=%b/%0d expected=%b/%0d at %0t",
                     tag, hit, hit_idx, exp[2], exp[1:0], $time);
        end
    endtask

    task automatic step(input logic we, input logic sel, input int idx,
                        input logic [31:0] wd, input logic v,
                        input logic [31:0] a, input logic st, input string tag);
        @(negedge clk);
        cfg_we = we; cfg_sel = sel; cfg_idx = 2'(idx); cfg_wdata = wd;
        acc_valid = v; acc_addr = a; acc_is_store = st;
        #1;
        compare(tag, model_hit(v, a, st));
        @(posedge clk);
        if (we) begin
            if (sel) m_ctrl[idx] = wd;
            else m_addr[idx] = wd;
        end
    endtask

    task automatic acc(input logic [31:0] a, input logic st, input string tag);
        step(1'b0, 1'b0, 0, 32'h0, 1'b1, a, st, tag);
    endtask

    task automatic wr(input logic sel, input int idx, input logic [31:0] wd);
        step(1'b1, sel, idx, wd, 1'b0, 32'h0, 1'b0, "R2");
    endtask

    localparam logic [31:0] LD = 32'h8000_0000;
    localparam logic [31:0] ST = 32'h4000_0000;

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NB; i++) begin
            m_addr[i] = '0; m_ctrl[i] = '0;
        end
        void'($urandom(32'd20240611));
        acc_valid = 1'b1; acc_addr = 32'h0;
        #13;
        compare("R1 in reset", 3'b000);
        @(negedge clk); rst_n = 1'b1;
        // R1 / R5: reset contents match address 0 but are inactive
        acc(32'h0, 1'b0, "R1");
        acc(32'h0, 1'b1, "R1");

        // R2: enable in the same cycle as a matching load -> old config used
        wr(1'b0, 0, 32'h100);
        step(1'b1, 1'b1, 0, LD | 32'h00, 1'b1, 32'h104, 1'b0, "R2 write cycle");
        acc(32'h104, 1'b0, "R2 next cycle");
        acc(32'h104, 1'b1, "R3 store ignored");
        acc(32'h13f, 1'b0, "R6 top of 64B");
        acc(32'h140, 1'b0, "R6 past region");
        acc(32'h0ff, 1'b0, "R6 below region");

        // R4: store-only 4-byte region
        wr(1'b0, 1, 32'h200);
        wr(1'b1, 1, ST | 32'h3c);
        acc(32'h203, 1'b1, "R4 store hit");
        acc(32'h204, 1'b1, "R6 4B edge");
        acc(32'h200, 1'b0, "R4 load ignored");

        // R7: non-contiguous masks
        wr(1'b0, 2, 32'h300);
        wr(1'b1, 2, LD | ST | 32'h35);
        acc(32'h30c, 1'b0, "R7 0x35 as 0x30");
        acc(32'h310, 1'b1, "R7 outside 16B");
        wr(1'b0, 3, 32'h400);
        wr(1'b1, 3, ST | 32'h1f);
        acc(32'h43f, 1'b1, "R7 0x1f as 0x00");

        // R8: two hits, lowest wins; then R5 after disable
        wr(1'b0, 0, 32'h300);
        acc(32'h30c, 1'b0, "R8 lowest index");
        step(1'b0, 1'b0, 0, 32'h0, 1'b0, 32'h30c, 1'b0, "R9 no valid");
        wr(1'b1, 0, 32'h3f);
        acc(32'h30c, 1'b0, "R5 disabled slot");
        wr(1'b1, 2, LD | 32'h3f);
        acc(32'h300, 1'b0, "R6 exact byte");
        acc(32'h301, 1'b0, "R6 exact byte miss");

        // Random mix of writes and accesses in a small window
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r;
            logic we, sel, v, st;
            logic [31:0] wd, a;
            int idx;
            r = $urandom;
            we = (r[1:0] == 2'b00);
            sel = r[2];
            idx = int'(r[4:3]);
            v = (r[7:5] != 3'b000);
            st = r[8];
            a = 32'h1000 | ($urandom & 32'h1ff) | (r[9] & r[10] ? 32'h1_0000 : 32'h0);
            if (sel) wd = {r[11], r[12], 24'h0, 6'($urandom)};
            else wd = 32'h1000 | ($urandom & 32'h1ff);
            step(we, sel, idx, wd, v, a, st, "R6 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule